// File: doc/BRIEF.md
# I2C Slave Transmit Controller

This block is the slave end of an I2C link for the case where the slave sends data to a master. It watches the bus for a start condition and compares the first frame after that start with its own 7-bit address. On a match it answers on the ninth clock with an acknowledge level that the host sets. If the read/write bit of that frame asks for a read, the block enters transmit mode by itself and presents a data-empty flag to the host.

The host supplies bytes through a single data register. Each time the empty flag rises, the host writes the next byte and then clears the flag. The block moves the byte into its shifter and sends it MSB first. The master returns an acknowledge after every byte. If a byte has gone out with an acknowledge and no new byte is waiting, the block sets a transmit-end flag and holds SCL low. It keeps holding SCL until the host either supplies another byte or performs end-of-transfer handling: clear the transmit-mode bit, then do a dummy read of the receive data port.

Both bus lines are open-drain. Each line has an output enable that pulls the wire low and an input that samples the wire. The inputs pass through a synchronizer before any edge is detected.

Top module: `i2cs_tx_ctrl`

## Requirements
- R1: While `enable` is 0 the block pulls neither SDA nor SCL low and does not acknowledge any frame.
- R2: Only the first frame after a start condition is compared with `own_addr`, and the address is in frame bits 7..1. On a mismatch the block drives no acknowledge, sets no flag, and ignores later frames until the next start condition.
- R3: On an address match the block drives SDA during the ninth clock with the level in `ack_level`, sampled at the match: 0 pulls SDA low (ACK) and 1 leaves it released.
- R4: If frame bit 0 (read/write) of a matched address frame is 1, `xmit_mode` and `tx_empty` are set with no host action. `rx_data` then holds the full address frame.
- R5: Data bytes go out MSB first. SDA output changes only while SCL is low.
- R6: Each move of the data register into the shifter sets `tx_empty`. If the host writes a byte and clears `tx_empty` before the ninth clock of the current byte falls, the next byte follows with no clock stretching.
- R7: When a byte ends with a master ACK and `tx_empty` is still 1, `tx_end` is set. A `clr_end` pulse clears it.
- R8: From the ninth SCL fall, SCL is held low while `tx_empty` is 1. It is released when the host clears `tx_empty`, in which case the next byte is sent, or when `xmit_mode` has been cleared by `clr_xmit` and an `rx_rd` pulse follows.
- R9: If the master NACKs a byte, the block releases SDA, does not stretch, does not set `tx_end`, and sends nothing more until a start or stop condition.
- R10: A stop condition returns the block to idle and clears `xmit_mode`. A repeated start clears `xmit_mode` and starts a new address comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable |
| own_addr | input | 7 | Own slave address |
| ack_level | input | 1 | Level driven on the address acknowledge clock (0 = ACK) |
| tx_wr | input | 1 | Write strobe for the transmit data register |
| tx_wdata | input | 8 | Transmit data |
| clr_empty | input | 1 | Clear pulse for `tx_empty` |
| clr_end | input | 1 | Clear pulse for `tx_end` |
| clr_xmit | input | 1 | Clear pulse for `xmit_mode` |
| rx_rd | input | 1 | Read strobe of the receive data port |
| rx_data | output | 8 | Last matched address frame |
| tx_empty | output | 1 | Transmit data register empty flag |
| tx_end | output | 1 | Transmission end flag |
| xmit_mode | output | 1 | Transmit mode bit |
| scl_i | input | 1 | SCL wire level |
| sda_i | input | 1 | SDA wire level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench sends a second frame carrying the block's own address after a mismatched frame, with no start between them. A design that compared every frame would acknowledge that second frame. The bench counts stretch cycles across a three-byte read that the host keeps fed, so a design that stretched on every byte boundary is caught. It also holds the bus after the final ACK to check that `tx_end` rises and that SCL stays low until the clear-mode-then-dummy-read sequence; clearing `tx_end` alone must not release SCL. A master NACK followed by a further byte of clocks must read back all ones. Repeated starts with a foreign address and with the own address check that a restart re-arms the address compare and drops transmit mode.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for a start condition
      ST_ADDR,   // shifting in the address frame
      ST_AACK,   // driving the address acknowledge
      ST_TXB,    // shifting a data byte out
      ST_MACK,   // sampling the master acknowledge
      ST_HOLD,   // stretching SCL, waiting for the host
      ST_PARK    // released, waiting for start or stop
   } state_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         prev  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], d_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = chain[STAGES-1] & ~prev;
   assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/i2cs_slave_fsm.sv
module i2cs_slave_fsm
   import i2cs_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ack_level,
   input  logic              scl_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              sda_rise,
   input  logic              sda_fall,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_empty,
   input  logic              xmit_mode,
   input  logic              rx_rd,
   output logic              sda_oe,
   output logic              scl_oe,
   output logic              set_xmit,
   output logic              set_empty,
   output logic              set_end,
   output logic              cap_valid,
   output logic [DATA_W-1:0] cap_byte,
   output logic              bus_cond,
   output logic              bus_stop,
   output state_t            st
);
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              rw, ackq, nack;
   logic              start, stop, act, hit, adr_done, do_load;

   assign start    = scl_lvl & sda_fall;
   assign stop     = scl_lvl & sda_rise;
   assign act      = enable & ~start & ~stop;
   assign hit      = (sh[DATA_W-1:1] == own_addr);
   assign adr_done = act && st == ST_ADDR && scl_fall && cnt == LAST;
   assign do_load  = act && !tx_empty &&
                     ((st == ST_AACK && scl_fall && rw) ||
                      (st == ST_MACK && scl_fall && !nack) ||
                      (st == ST_HOLD));

   assign set_xmit  = adr_done & hit & sh[0];
   assign set_empty = set_xmit | do_load;
   assign set_end   = act && st == ST_MACK && scl_fall && !nack && tx_empty;
   assign cap_valid = adr_done & hit;
   assign cap_byte  = sh;
   assign bus_cond  = start | stop;
   assign bus_stop  = stop;

   assign sda_oe = (st == ST_AACK && !ackq) || (st == ST_TXB && !sh[DATA_W-1]);
   assign scl_oe = (st == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         sh   <= '0;
         cnt  <= '0;
         rw   <= 1'b0;
         ackq <= 1'b0;
         nack <= 1'b0;
      end else if (!enable || stop) begin
         st <= ST_IDLE;
      end else if (start) begin
         st  <= ST_ADDR;
         cnt <= '0;
      end else if (do_load) begin
         sh  <= tx_data;
         cnt <= '0;
         st  <= ST_TXB;
      end else begin
         case (st)
            ST_ADDR: begin
               if (scl_rise) begin
                  sh  <= {sh[DATA_W-2:0], sda_lvl};
                  cnt <= cnt + 1'b1;
               end else if (adr_done) begin
                  if (hit) begin
                     st   <= ST_AACK;
                     rw   <= sh[0];
                     ackq <= ack_level;
                  end else begin
                     st <= ST_PARK;
                  end
               end
            end
            ST_AACK: if (scl_fall) st <= rw ? ST_HOLD : ST_PARK;
            ST_TXB: begin
               if (scl_rise) cnt <= cnt + 1'b1;
               else if (scl_fall) begin
                  if (cnt == LAST) st <= ST_MACK;
                  else             sh <= {sh[DATA_W-2:0], 1'b0};
               end
            end
            ST_MACK: begin
               if (scl_rise) nack <= sda_lvl;
               else if (scl_fall) st <= nack ? ST_PARK : ST_HOLD;
            end
            ST_HOLD: if (rx_rd && !xmit_mode) st <= ST_PARK;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2cs_tx_ctrl.sv
module i2cs_tx_ctrl
   import i2cs_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ack_level,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              clr_empty,
   input  logic              clr_end,
   input  logic              clr_xmit,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_empty,
   output logic              tx_end,
   output logic              xmit_mode,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe
);
   localparam int LINES = 2;   // index 0 = SCL, 1 = SDA

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("DATA_W must equal ADDR_W + 1");
   end

   logic [LINES-1:0] pin, lvl, rise, fall;
   assign pin = {sda_i, scl_i};

   for (genvar g = 0; g < LINES; g++) begin : g_sync
      i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_i(pin[g]),
         .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g])
      );
   end

   logic              scl_lvl;
   logic [DATA_W-1:0] data_q, cap_byte;
   logic              set_xmit, set_empty, set_end, cap_valid, bus_cond, bus_stop;
   state_t            st;

   assign scl_lvl = lvl[0];

   i2cs_slave_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(own_addr),
      .ack_level(ack_level), .scl_lvl(lvl[0]), .scl_rise(rise[0]),
      .scl_fall(fall[0]), .sda_lvl(lvl[1]), .sda_rise(rise[1]),
      .sda_fall(fall[1]), .tx_data(data_q), .tx_empty(tx_empty),
      .xmit_mode(xmit_mode), .rx_rd(rx_rd), .sda_oe(sda_oe), .scl_oe(scl_oe),
      .set_xmit(set_xmit), .set_empty(set_empty), .set_end(set_end),
      .cap_valid(cap_valid), .cap_byte(cap_byte), .bus_cond(bus_cond),
      .bus_stop(bus_stop), .st(st)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         rx_data   <= '0;
         tx_empty  <= 1'b0;
         tx_end    <= 1'b0;
         xmit_mode <= 1'b0;
      end else begin
         if (tx_wr) data_q <= tx_wdata;
         if (cap_valid) rx_data <= cap_byte;
         if (set_empty)      tx_empty <= 1'b1;
         else if (clr_empty) tx_empty <= 1'b0;
         if (set_end)      tx_end <= 1'b1;
         else if (clr_end) tx_end <= 1'b0;
         if (set_xmit)                 xmit_mode <= 1'b1;
         else if (bus_cond || clr_xmit) xmit_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/i2cs_tx_chk.sv
module i2cs_tx_chk
   import i2cs_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   enable,
   input logic   scl_lvl,
   input logic   sda_oe,
   input logic   scl_oe,
   input logic   tx_empty,
   input logic   tx_end,
   input logic   xmit_mode,
   input logic   bus_stop,
   input state_t st
);
   AST_OFF_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sda_oe && !scl_oe)); // R1
   AST_XMIT_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xmit_mode) |-> $past(st == ST_ADDR)); // R4
   AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe)); // R5
   AST_END_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_end) |-> $past(tx_empty)); // R7
   AST_STRETCH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe && !tx_empty) |=> !scl_oe); // R8
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stop |=> (!xmit_mode && !scl_oe && !sda_oe)); // R10
endmodule

bind i2cs_tx_ctrl i2cs_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .scl_lvl(scl_lvl),
   .sda_oe(sda_oe), .scl_oe(scl_oe), .tx_empty(tx_empty), .tx_end(tx_end),
   .xmit_mode(xmit_mode), .bus_stop(bus_stop), .st(st)
);

// File: tb/i2cs_tx_ctrl_tb.sv
module i2cs_tx_ctrl_tb;
   localparam int CLK_P = 10;
   localparam int Q     = 12;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ack_level = 1'b0;
   logic tx_wr = 1'b0, clr_empty = 1'b0, clr_end = 1'b0, clr_xmit = 1'b0, rx_rd = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic [7:0] rx_data;
   logic tx_empty, tx_end, xmit_mode, scl_oe, sda_oe;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic scl_line, sda_line;
   int tests = 0, fails = 0, viol = 0, stretch = 0;
   logic prev_scl = 1'b1, prev_oe = 1'b0;

   assign scl_line = !(m_scl_low || scl_oe);
   assign sda_line = !(m_sda_low || sda_oe);

   always #(CLK_P/2) clk = ~clk;

   i2cs_tx_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .own_addr(OWN),
      .ack_level(ack_level), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .clr_empty(clr_empty), .clr_end(clr_end), .clr_xmit(clr_xmit),
      .rx_rd(rx_rd), .rx_data(rx_data), .tx_empty(tx_empty), .tx_end(tx_end),
      .xmit_mode(xmit_mode), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   // monitor: SDA drive must not move while SCL is high (R5); stretch counter (R6)
   always @(negedge clk) begin
      if (rst_n && scl_line && prev_scl && sda_oe != prev_oe) viol++;
      if (scl_oe) stretch++;
      prev_scl = scl_line;
      prev_oe  = sda_oe;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- master side ----------------
   task automatic m_bit(input logic b, output logic r);
      m_sda_low = !b;
      cyc(Q);
      m_scl_low = 1'b0;
      do @(negedge clk); while (!scl_line);
      cyc(Q);
      r = sda_line;
      cyc(Q);
      m_scl_low = 1'b1;
      cyc(2);
   endtask

   task automatic m_start();
      m_sda_low = 1'b0;
      cyc(Q);
      m_scl_low = 1'b0;
      do @(negedge clk); while (!scl_line);
      cyc(Q);
      m_sda_low = 1'b1;
      cyc(Q);
      m_scl_low = 1'b1;
      cyc(Q);
   endtask

   task automatic m_stop();
      m_sda_low = 1'b1;
      cyc(Q);
      m_scl_low = 1'b0;
      do @(negedge clk); while (!scl_line);
      cyc(Q);
      m_sda_low = 1'b0;
      cyc(2*Q);
   endtask

   task automatic m_write(input logic [7:0] b, output logic ack_bit);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(b[i], r);
      m_bit(1'b1, ack_bit);
   endtask

   task automatic m_read(output logic [7:0] d, input logic give_ack);
      logic r;
      d = '0;
      for (int i = 0; i < 8; i++) begin
         m_bit(1'b1, r);
         d = {d[6:0], r};
      end
      m_bit(!give_ack, r);
   endtask

   // ---------------- host side ----------------
   task automatic h_write(input logic [7:0] d);
      @(negedge clk); tx_wdata = d; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
   endtask
   task automatic h_clr_empty();
      @(negedge clk); clr_empty = 1'b1;
      @(negedge clk); clr_empty = 1'b0;
   endtask
   task automatic h_clr_end();
      @(negedge clk); clr_end = 1'b1;
      @(negedge clk); clr_end = 1'b0;
   endtask
   task automatic h_end_xfer();
      @(negedge clk); clr_xmit = 1'b1;
      @(negedge clk); clr_xmit = 1'b0; rx_rd = 1'b1;
      @(negedge clk); rx_rd = 1'b0;
   endtask
   task automatic h_feed(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
      logic [7:0] q [3];
      q[0] = b0; q[1] = b1; q[2] = b2;
      for (int k = 0; k < 3; k++) begin
         do @(negedge clk); while (!(tx_empty && xmit_mode));
         h_write(q[k]);
         h_clr_empty();
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("reset", "sda_oe", sda_oe, 0);
      chk("reset", "scl_oe", scl_oe, 0);
      chk("reset", "flags", {tx_empty, tx_end, xmit_mode}, 0);
   endtask

   task automatic t_disabled();
      logic a;
      enable = 1'b0;
      m_start();
      m_write({OWN, 1'b1}, a);
      chk("R1", "ack while disabled", a, 1);
      chk("R1", "xmit_mode while disabled", xmit_mode, 0);
      m_stop();
      enable = 1'b1;
      cyc(4);
   endtask

   task automatic t_mismatch();
      logic a;
      m_start();
      m_write({OWN ^ 7'h01, 1'b1}, a);
      chk("R2", "ack on foreign address", a, 1);
      m_write({OWN, 1'b1}, a);
      chk("R2", "ack on own address in second frame", a, 1);
      chk("R2", "flags after mismatch", {tx_empty, xmit_mode}, 0);
      m_stop();
   endtask

   task automatic t_read3();
      logic a;
      logic [7:0] d0, d1, d2;
      int s_mid;
      ack_level = 1'b0;
      stretch = 0;
      fork
         h_feed(8'hA5, 8'h3C, 8'hF0);
         begin
            m_start();
            m_write({OWN, 1'b1}, a);
            chk("R3", "address ack level 0", a, 0);
            chk("R4", "xmit_mode after read match", xmit_mode, 1);
            chk("R4", "rx_data holds address frame", rx_data, {OWN, 1'b1});
            m_read(d0, 1'b1);
            m_read(d1, 1'b1);
            s_mid = stretch;
            m_read(d2, 1'b1);
            chk("R5", "byte 0", d0, 8'hA5);
            chk("R5", "byte 1", d1, 8'h3C);
            chk("R6", "byte 2", d2, 8'hF0);
            chk("R6", "stretch cycles while host keeps up", s_mid, 0);
         end
      join
      cyc(20);
      chk("R7", "tx_end after last ACK", tx_end, 1);
      chk("R7", "tx_empty at end", tx_empty, 1);
      chk("R8", "SCL held at end", scl_oe, 1);
      h_clr_end();
      cyc(2);
      chk("R7", "tx_end cleared", tx_end, 0);
      chk("R8", "SCL still held after clr_end", scl_oe, 1);
      h_end_xfer();
      cyc(3);
      chk("R8", "SCL released after end processing", scl_oe, 0);
      chk("R8", "xmit_mode after clr_xmit", xmit_mode, 0);
      m_stop();
      chk("R10", "xmit_mode after stop", xmit_mode, 0);
   endtask

   task automatic t_nack_restart();
      logic a;
      logic [7:0] d;
      m_start();
      m_write({OWN, 1'b1}, a);
      cyc(10);
      chk("R4", "tx_empty set with no host action", tx_empty, 1);
      chk("R4", "xmit_mode set", xmit_mode, 1);
      chk("R8", "SCL stretched before first byte", scl_oe, 1);
      h_write(8'h81);
      h_clr_empty();
      m_read(d, 1'b0);
      chk("R5", "byte before NACK", d, 8'h81);
      cyc(10);
      chk("R9", "no stretch after NACK", scl_oe, 0);
      chk("R9", "SDA released after NACK", sda_oe, 0);
      chk("R9", "tx_end after NACK", tx_end, 0);
      m_read(d, 1'b0);
      chk("R9", "bus after NACK", d, 8'hFF);
      m_start();
      chk("R10", "xmit_mode after repeated start", xmit_mode, 0);
      m_write({OWN ^ 7'h02, 1'b0}, a);
      chk("R10", "ack on foreign address after restart", a, 1);
      ack_level = 1'b1;
      m_start();
      m_write({OWN, 1'b0}, a);
      chk("R3", "address ack level 1", a, 1);
      ack_level = 1'b0;
      m_start();
      m_write({OWN, 1'b0}, a);
      chk("R10", "ack on own address after restart", a, 0);
      chk("R10", "write match leaves xmit_mode", xmit_mode, 0);
      m_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      cyc(5);
      rst_n = 1'b1;
      cyc(5);
      t_reset();
      t_disabled();
      t_mismatch();
      t_read3();
      t_nack_restart();
      chk("R5", "SDA changes while SCL high", viol, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule